// File: doc/BRIEF.md
# Reset-Time Bypass Transceiver

This block turns the two 36-bit ports of a bidirectional buffer into a registered transceiver for as long as the active-low reset input is held low. During that window the internal storage is not used. A master processor on port A can hand configuration words to a peripheral on port B, or fetch words back from it, one clocked transfer at a time.

Port A is the master. On each rising clock edge, a transfer takes place when three things are true: reset is low, port A enable is high and port A request is high. The port A read/write input picks the direction, and reset does not override it. Port B has no transfer controls of its own. Its data input is only sampled when port A calls for a B-to-A transfer.

Each port has an output register, a data-output enable and a drive-enable output. A port drives only when its output enable is high, bypass is active and the last transfer was aimed at that port. Outside bypass, both output registers are held at zero and nothing is driven. A `bypass_on` flag reports the registered mode.

Top module: `bypass_xcvr`

## Requirements
- R1: `bypass_on` is 1 after a rising edge that samples `rst_n` low, and 0 after a rising edge that samples `rst_n` high.
- R2: After an edge that samples `rst_n` high, no transfer takes place: `a_dout` and `b_dout` are zero and both drive enables are 0, whatever the port A controls and data are.
- R3: An edge that samples `rst_n`=0, `a_en`=1, `a_req`=1 and `a_rnw`=0 (A to B) loads `a_din` into `b_dout`.
- R4: An edge that samples `rst_n`=0, `a_en`=1, `a_req`=1 and `a_rnw`=1 (B to A) loads `b_din` into `a_dout`.
- R5: An edge in bypass where `a_en` or `a_req` is 0 leaves both output registers unchanged.
- R6: Changes on `a_din` or `b_din` between transfers do not reach the outputs. Data is captured only at a transfer edge.
- R7: `b_dout_en` is 1 exactly when `b_oe` is 1, `bypass_on` is 1 and the last transfer in this bypass window was A to B. `a_dout_en` is 1 exactly when `a_oe` is 1, `bypass_on` is 1 and the last transfer was B to A.
- R8: On entry to bypass, both output registers start at zero and neither port drives until a transfer occurs.
- R9: The direction can be switched freely while reset is low. A transfer updates only its destination register, and the other register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; bypass mode while low |
| a_en | input | 1 | Port A enable |
| a_req | input | 1 | Port A request |
| a_rnw | input | 1 | Port A direction: 0 = A to B, 1 = B to A |
| a_oe | input | 1 | Port A output enable, active high |
| b_oe | input | 1 | Port B output enable, active high |
| a_din | input | 36 | Data arriving on port A |
| b_din | input | 36 | Data arriving on port B |
| a_dout | output | 36 | Port A output register |
| a_dout_en | output | 1 | Port A bus drive enable |
| b_dout | output | 36 | Port B output register |
| b_dout_en | output | 1 | Port B bus drive enable |
| bypass_on | output | 1 | Registered bypass-mode flag |

## Verification
Transfers are exercised with three data patterns: all ones, alternating 1010 and 0101 halves, and a single set bit. These show whether a word crosses complete and without swapped or stuck bits. Enable-only and request-only edges show whether the gate needs both inputs. Alternating A-to-B and B-to-A transfers show whether each direction writes only its own register and moves the drive enable. Toggling the output enables without a clock edge, and changing the data inputs between transfers, separate the combinational drive logic from the registered capture. Leaving bypass and entering it again shows that both registers clear.

// File: rtl/bx_pkg.sv
// Shared types for the reset-time bypass transceiver.
// Assumes: exactly two transfer directions, A to B and B to A.
package bx_pkg;
    localparam int NUM_DIR = 2;
    localparam int DIR_AB  = 0;
    localparam int DIR_BA  = 1;

    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_A    = 2'd1,
        DEST_B    = 2'd2
    } dest_e;
endpackage

// File: rtl/bx_ctrl.sv
// Mode and transfer decode for the bypass transceiver.
// Registers the bypass flag and the destination of the last transfer.
// Decodes the per-direction load strobes.
// Assumes: rst_n is synchronous to clk; port A alone controls transfers.
module bx_ctrl
    import bx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  a_en,
    input  logic  a_req,
    input  logic  a_rnw,
    output logic  load_ab,
    output logic  load_ba,
    output logic  bypass_q,
    output dest_e dest_q
);
    logic xfer;

    // Transfer strobe: bypass active and master enable and request both high.
    always_comb begin
        xfer    = !rst_n && a_en && a_req;
        load_ab = xfer && !a_rnw;
        load_ba = xfer &&  a_rnw;
    end

    // Registered mode flag follows the sampled reset level.
    always_ff @(posedge clk) begin
        bypass_q <= !rst_n;
    end

    // Tracks which port received the last transfer; cleared outside bypass.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            dest_q <= DEST_NONE;
        end else if (load_ab) begin
            dest_q <= DEST_B;
        end else if (load_ba) begin
            dest_q <= DEST_A;
        end
    end
endmodule

// File: rtl/bx_lane.sv
// One direction of the bypass path: a W-bit output register.
// Held at zero outside bypass; loads on its strobe; holds otherwise.
// Assumes: load is only asserted while bypass is active.
module bx_lane #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         bypass,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Output register: zero outside bypass, capture on load.
    always_ff @(posedge clk) begin
        if (!bypass) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/bx_drive.sv
// Bus drive decision for both ports.
// A port drives when its output enable is high, bypass is active and it
// was the destination of the last transfer.
// Assumes: dest is DEST_NONE whenever bypass is inactive.
module bx_drive
    import bx_pkg::*;
(
    input  logic  bypass_q,
    input  dest_e dest_q,
    input  logic  a_oe,
    input  logic  b_oe,
    output logic  a_drv,
    output logic  b_drv
);
    // Combinational drive enables per port.
    always_comb begin
        a_drv = bypass_q && a_oe && (dest_q == DEST_A);
        b_drv = bypass_q && b_oe && (dest_q == DEST_B);
    end
endmodule

// File: rtl/bypass_xcvr.sv
// Reset-time bypass transceiver top.
// While rst_n is low, port A moves registered words to or from port B in
// the direction a_rnw selects. Port B has no transfer controls.
// Assumes: data widths of both ports are equal (DATA_W).
module bypass_xcvr
    import bx_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_req,
    input  logic              a_rnw,
    input  logic              a_oe,
    input  logic              b_oe,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_dout_en,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_dout_en,
    output logic              bypass_on
);
    logic              load_ab;
    logic              load_ba;
    logic              bypass_q;
    dest_e             dest_q;
    logic              lane_ld [NUM_DIR];
    logic [DATA_W-1:0] lane_d  [NUM_DIR];
    logic [DATA_W-1:0] lane_q  [NUM_DIR];

    bx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_en     (a_en),
        .a_req    (a_req),
        .a_rnw    (a_rnw),
        .load_ab  (load_ab),
        .load_ba  (load_ba),
        .bypass_q (bypass_q),
        .dest_q   (dest_q)
    );

    // Lane inputs: lane DIR_AB feeds port B, lane DIR_BA feeds port A.
    always_comb begin
        lane_ld[DIR_AB] = load_ab;
        lane_ld[DIR_BA] = load_ba;
        lane_d[DIR_AB]  = a_din;
        lane_d[DIR_BA]  = b_din;
    end

    for (genvar i = 0; i < NUM_DIR; i++) begin : g_lane
        bx_lane #(.W(DATA_W)) u_lane (
            .clk    (clk),
            .bypass (!rst_n),
            .load   (lane_ld[i]),
            .din    (lane_d[i]),
            .q      (lane_q[i])
        );
    end

    bx_drive u_drive (
        .bypass_q (bypass_q),
        .dest_q   (dest_q),
        .a_oe     (a_oe),
        .b_oe     (b_oe),
        .a_drv    (a_dout_en),
        .b_drv    (b_dout_en)
    );

    // Output mapping.
    always_comb begin
        b_dout    = lane_q[DIR_AB];
        a_dout    = lane_q[DIR_BA];
        bypass_on = bypass_q;
    end
endmodule

// File: rtl/bypass_xcvr_chk.sv
// Property checker for bypass_xcvr, attached by bind.
// Assumes: the checker only sees top-level ports. A two-edge warm-up
// counter stands in for reset qualification, because rst_n is the mode
// input of this block.
module bypass_xcvr_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en,
    input logic              a_req,
    input logic              a_rnw,
    input logic              a_oe,
    input logic              b_oe,
    input logic [DATA_W-1:0] a_din,
    input logic [DATA_W-1:0] b_din,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_dout_en,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_dout_en,
    input logic              bypass_on
);
    logic [1:0] warm = 2'd0;
    logic       armed;

    // Warm-up counter: arms the properties after two clock edges.
    always_ff @(posedge clk) begin
        if (warm != 2'd3) warm <= warm + 2'd1;
    end
    assign armed = (warm >= 2'd2);

    a_r1_mode_on: assert property (@(posedge clk) disable iff (!armed)
        !rst_n |=> bypass_on);
    a_r1_mode_off: assert property (@(posedge clk) disable iff (!armed)
        rst_n |=> !bypass_on);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!armed)
        rst_n |=> (a_dout == '0 && b_dout == '0 && !a_dout_en && !b_dout_en));
    a_r3_a_to_b: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && a_en && a_req && !a_rnw) |=> (b_dout == $past(a_din)));
    a_r4_b_to_a: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && a_en && a_req && a_rnw) |=> (a_dout == $past(b_din)));
    a_r5_no_strobe_hold: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && !(a_en && a_req)) |=> ($stable(a_dout) && $stable(b_dout)));
    a_r7_a_drive: assert property (@(posedge clk) disable iff (!armed)
        a_dout_en |-> (a_oe && bypass_on));
    a_r7_b_drive: assert property (@(posedge clk) disable iff (!armed)
        b_dout_en |-> (b_oe && bypass_on));
    a_r7_one_driver: assert property (@(posedge clk) disable iff (!armed)
        !(a_dout_en && b_dout_en));
    a_r9_ab_keeps_a: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && a_en && a_req && !a_rnw) |=> $stable(a_dout));
    a_r9_ba_keeps_b: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && a_en && a_req && a_rnw) |=> $stable(b_dout));
endmodule

bind bypass_xcvr bypass_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_en      (a_en),
    .a_req     (a_req),
    .a_rnw     (a_rnw),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .a_din     (a_din),
    .b_din     (b_din),
    .a_dout    (a_dout),
    .a_dout_en (a_dout_en),
    .b_dout    (b_dout),
    .b_dout_en (b_dout_en),
    .bypass_on (bypass_on)
);

// File: tb/bypass_xcvr_test.sv
// Directed bench for bypass_xcvr: one task per scenario.
module bypass_xcvr_test;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         a_en = 1'b0, a_req = 1'b0, a_rnw = 1'b0;
    logic         a_oe = 1'b0, b_oe = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_dout_en, b_dout_en, bypass_on;
    int           checks = 0;
    int           errors = 0;
    logic         done = 1'b0;

    always #2.5 clk = ~clk;

    bypass_xcvr #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_req(a_req), .a_rnw(a_rnw),
        .a_oe(a_oe), .b_oe(b_oe), .a_din(a_din), .b_din(b_din),
        .a_dout(a_dout), .a_dout_en(a_dout_en), .b_dout(b_dout),
        .b_dout_en(b_dout_en), .bypass_on(bypass_on)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change on the falling edge, sampling 1 ns after rising.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic setin();
        @(negedge clk);
    endtask

    task automatic t_idle();
        setin();
        rst_n = 1'b1; a_en = 1'b1; a_req = 1'b1; a_rnw = 1'b0;
        a_oe = 1'b1; b_oe = 1'b1; a_din = {W{1'b1}}; b_din = {W{1'b1}};
        step(); step();
        chk("R1 bypass off", W'(bypass_on), '0);
        chk("R2 b_dout zero", b_dout, '0);
        chk("R2 a_dout zero", a_dout, '0);
        chk("R2 no drive", W'({a_dout_en, b_dout_en}), '0);
    endtask

    task automatic t_enter();
        setin();
        rst_n = 1'b0; a_en = 1'b0; a_req = 1'b0;
        step();
        chk("R1 bypass on", W'(bypass_on), W'(1));
        chk("R8 entry a_dout", a_dout, '0);
        chk("R8 entry b_dout", b_dout, '0);
        chk("R8 entry no drive", W'({a_dout_en, b_dout_en}), '0);
    endtask

    task automatic t_write(input logic [W-1:0] d);
        setin();
        a_en = 1'b1; a_req = 1'b1; a_rnw = 1'b0; a_din = d; b_oe = 1'b1;
        step();
        chk("R3 A to B data", b_dout, d);
        chk("R7 b drives", W'(b_dout_en), W'(1));
        chk("R7 a idle", W'(a_dout_en), '0);
        setin();
        a_en = 1'b0; a_req = 1'b0;
    endtask

    task automatic t_gate(input logic [W-1:0] held);
        setin();
        a_en = 1'b1; a_req = 1'b0; a_rnw = 1'b0; a_din = ~held;
        step();
        chk("R5 req low holds", b_dout, held);
        setin();
        a_en = 1'b0; a_req = 1'b1;
        step();
        chk("R5 en low holds", b_dout, held);
        setin();
        a_req = 1'b0;
    endtask

    task automatic t_read(input logic [W-1:0] d, input logic [W-1:0] b_held);
        setin();
        a_en = 1'b1; a_req = 1'b1; a_rnw = 1'b1; b_din = d; a_oe = 1'b1;
        step();
        chk("R4 B to A data", a_dout, d);
        chk("R9 b_dout kept", b_dout, b_held);
        chk("R7 a drives", W'(a_dout_en), W'(1));
        chk("R7 b released", W'(b_dout_en), '0);
        setin();
        a_en = 1'b0; a_req = 1'b0;
    endtask

    task automatic t_hold(input logic [W-1:0] a_held, input logic [W-1:0] b_held);
        setin();
        b_din = ~a_held; a_din = ~b_held;
        step(); step();
        chk("R6 a_dout ignores b_din", a_dout, a_held);
        chk("R6 b_dout ignores a_din", b_dout, b_held);
    endtask

    task automatic t_oe();
        setin();
        a_oe = 1'b0;
        #1;
        chk("R7 a_oe low", W'(a_dout_en), '0);
        a_oe = 1'b1;
        #1;
        chk("R7 a_oe high", W'(a_dout_en), W'(1));
    endtask

    task automatic t_exit_reenter();
        setin();
        rst_n = 1'b1;
        step();
        chk("R1 exit", W'(bypass_on), '0);
        chk("R2 exit a_dout", a_dout, '0);
        chk("R2 exit b_dout", b_dout, '0);
        t_enter();
    endtask

    initial begin
        #2000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_enter();
        t_write({W{1'b1}});
        t_gate({W{1'b1}});
        t_read({(W/2){2'b10}}, {W{1'b1}});
        t_write({(W/2){2'b01}});
        chk("R9 a_dout kept", a_dout, {(W/2){2'b10}});
        t_hold({(W/2){2'b10}}, {(W/2){2'b01}});
        t_read(W'(1) << 17, {(W/2){2'b01}});
        t_oe();
        t_exit_reenter();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule